// File: doc/BRIEF.md
# Queued DMA Request Scheduler

This block sits between a request front end and a single-channel DMA engine. Each request has already been checked and carries a source address, a destination address and a byte count, all inside one page. Requests go into one of two hardware queues instead of a single register set. The queue is picked by a privilege bit on the request: privileged requests from system software use the high-priority queue, and all other requests use the low-priority queue. A request is turned away only when its own queue is full. Otherwise it waits its turn and is then issued to the engine. The engine runs one transfer at a time.

Requests from many issuers can be outstanding together, so a gather or scatter chain can be posted as a run of requests. Because the queues are first-in first-out and only one transfer runs at a time, completion of a whole chain is known once its last request has retired. A page-reference port lets system software supply a physical page number and learn in the same cycle whether any waiting or running request names that page as source or destination. The software can then decide whether the page may be remapped, without pinning it.

Top module: `dmaq_sched`

## Requirements
- R1: After reset both queues are empty, `busy` and `eng_start` are low, `req_full` is low for either privilege value, and `qry_hit` is low for every page.
- R2: `req_full` is a combinational signal that is high in the same cycle exactly when the queue picked by `req_priv` (1 = high-priority, 0 = low-priority) already holds DEPTH entries. A request with `req_valid` high and `req_full` low is accepted at the clock edge.
- R3: Each queue holds DEPTH (default 8) entries. A request presented while its queue is full is dropped: it is never issued and its pages never hit.
- R4: Requests in the same queue are issued in the order they were accepted, and the source, destination and count fields reach the engine unchanged.
- R5: When the engine is idle at a clock edge and both queues hold entries, the head of the high-priority queue is issued. The low-priority queue is issued only when the high-priority queue is empty.
- R6: When the engine is idle and some queue is non-empty at a clock edge, that edge moves the head entry to the active set. `eng_start` is then high for exactly the next cycle, with `eng_src`, `eng_dst` and `eng_cnt` showing the entry. No request is issued while `busy` is high.
- R7: `eng_done` high at a clock edge while `busy` is high retires the active entry, so `busy` is low in the next cycle. `eng_done` while idle has no effect.
- R8: `qry_hit` is a combinational signal that is high in the same cycle exactly when `qry_page` equals the page number (address bits [ADDR_W-1:PAGE_SHIFT]) of the source or destination of any entry in either queue or in the active set.
- R9: Once the last request of a posted chain has retired and both queues are empty, `busy` is low and no page of the chain hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A request is presented |
| req_priv | input | 1 | 1 = privileged, high-priority queue; 0 = low-priority queue |
| req_src | input | 16 | Source physical address |
| req_dst | input | 16 | Destination physical address |
| req_cnt | input | 12 | Byte count |
| req_full | output | 1 | Target queue full; the request is refused this cycle |
| eng_start | output | 1 | One-cycle start pulse to the engine |
| eng_src | output | 16 | Active source address |
| eng_dst | output | 16 | Active destination address |
| eng_cnt | output | 12 | Active byte count |
| eng_done | input | 1 | Engine has finished the active transfer |
| busy | output | 1 | An active transfer is held |
| qry_page | input | 8 | Physical page number to look up |
| qry_hit | output | 1 | The page is named by a queued or active request |

## Verification
The bench builds the block with its defaults: 16-bit addresses, 256-byte pages (PAGE_SHIFT 8) and a queue depth of 8. With a depth of 8, a stalled engine fills a queue to the refusal point within about ten cycles, so the full and drop cases come up often, both in the directed section and during random traffic. Random addresses are drawn from only sixteen pages, so page lookups hit and miss in roughly equal measure. Random privilege bits and a random engine-done rate keep both queues occupied together often enough to exercise the priority choice many times.

// File: rtl/dmaq_pkg.sv
package dmaq_pkg;
    localparam int ADDR_W = 16;
    localparam int CNT_W  = 12;

    typedef struct packed {
        logic [ADDR_W-1:0] src;
        logic [ADDR_W-1:0] dst;
        logic [CNT_W-1:0]  cnt;
    } xfer_t;
endpackage

// File: rtl/dmaq_fifo.sv
module dmaq_fifo
    import dmaq_pkg::*;
#(
    parameter int DEPTH      = 8,
    parameter int PAGE_SHIFT = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  xfer_t                        push_data,
    input  logic                         pop,
    output xfer_t                        head,
    output logic                         empty,
    output logic                         full,
    input  logic [ADDR_W-PAGE_SHIFT-1:0] qry_page,
    output logic                         qry_hit
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int OCC_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PTR_W-1:0] wp;
        logic [PTR_W-1:0] rp;
        logic [OCC_W-1:0] n;
    } ptr_t;

    ptr_t                    st_d, st_q;
    xfer_t [DEPTH-1:0]       mem_d, mem_q;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty = (st_q.n == '0);
    assign full  = (st_q.n == OCC_W'(DEPTH));
    assign head  = mem_q[st_q.rp];

    always_comb begin
        st_d  = st_q;
        mem_d = mem_q;
        if (push) begin
            mem_d[st_q.wp] = push_data;
            st_d.wp        = bump(st_q.wp);
        end
        if (pop) st_d.rp = bump(st_q.rp);
        case ({push, pop})
            2'b10:   st_d.n = st_q.n + 1'b1;
            2'b01:   st_d.n = st_q.n - 1'b1;
            default: st_d.n = st_q.n;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= '0;
            mem_q <= '0;
        end else begin
            st_q  <= st_d;
            mem_q <= mem_d;
        end
    end

    // associative page lookup across occupied slots
    always_comb begin
        int slot;
        qry_hit = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            slot = int'(st_q.rp) + i;
            if (slot >= DEPTH) slot = slot - DEPTH;
            if (i < int'(st_q.n)) begin
                if (mem_q[slot].src[ADDR_W-1:PAGE_SHIFT] == qry_page ||
                    mem_q[slot].dst[ADDR_W-1:PAGE_SHIFT] == qry_page)
                    qry_hit = 1'b1;
            end
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) push |-> !full); // R2
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n) pop |-> !empty); // R4
    AST_OCC_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop) |=> (st_q.n == $past(st_q.n) + 1'b1)); // R3
endmodule

// File: rtl/dmaq_active.sv
module dmaq_active
    import dmaq_pkg::*;
#(
    parameter int PAGE_SHIFT = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         load,
    input  xfer_t                        load_data,
    input  logic                         load_priv,
    input  logic                         done,
    output logic                         busy,
    output logic                         start,
    output logic                         cur_priv,
    output xfer_t                        cur,
    input  logic [ADDR_W-PAGE_SHIFT-1:0] qry_page,
    output logic                         qry_hit
);
    typedef struct packed {
        logic  busy;
        logic  start;
        logic  priv;
        xfer_t x;
    } act_t;

    act_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.start = 1'b0;
        if (st_q.busy && done) st_d.busy = 1'b0;
        if (load) begin
            st_d.busy  = 1'b1;
            st_d.start = 1'b1;
            st_d.priv  = load_priv;
            st_d.x     = load_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy     = st_q.busy;
    assign start    = st_q.start;
    assign cur_priv = st_q.priv;
    assign cur      = st_q.x;
    assign qry_hit  = st_q.busy &&
                      (st_q.x.src[ADDR_W-1:PAGE_SHIFT] == qry_page ||
                       st_q.x.dst[ADDR_W-1:PAGE_SHIFT] == qry_page);

    AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n) start |=> !start); // R6
    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n) start |-> busy); // R6
    AST_LOAD_IDLE: assert property (@(posedge clk) disable iff (!rst_n) load |-> !busy); // R6
    AST_DONE_RETIRE: assert property (@(posedge clk) disable iff (!rst_n) (busy && done) |=> !busy); // R7
endmodule

// File: rtl/dmaq_sched.sv
module dmaq_sched
    import dmaq_pkg::*;
#(
    parameter int DEPTH      = 8,
    parameter int PAGE_SHIFT = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         req_valid,
    input  logic                         req_priv,
    input  logic [ADDR_W-1:0]            req_src,
    input  logic [ADDR_W-1:0]            req_dst,
    input  logic [CNT_W-1:0]             req_cnt,
    output logic                         req_full,
    output logic                         eng_start,
    output logic [ADDR_W-1:0]            eng_src,
    output logic [ADDR_W-1:0]            eng_dst,
    output logic [CNT_W-1:0]             eng_cnt,
    input  logic                         eng_done,
    output logic                         busy,
    input  logic [ADDR_W-PAGE_SHIFT-1:0] qry_page,
    output logic                         qry_hit
);
    localparam int NQ = 2;   // index 1 = privileged queue

    xfer_t           req_x;
    xfer_t           head [NQ];
    logic [NQ-1:0]   push, pop, empty, full, q_hit;
    logic            dispatch, sel_hi, act_hit, act_priv;
    xfer_t           load_x, cur_x;

    assign req_x = '{src: req_src, dst: req_dst, cnt: req_cnt};

    for (genvar q = 0; q < NQ; q++) begin : g_queue
        assign push[q] = req_valid && (int'(req_priv) == q) && !full[q];
        dmaq_fifo #(.DEPTH(DEPTH), .PAGE_SHIFT(PAGE_SHIFT)) u_fifo (
            .clk       (clk),
            .rst_n     (rst_n),
            .push      (push[q]),
            .push_data (req_x),
            .pop       (pop[q]),
            .head      (head[q]),
            .empty     (empty[q]),
            .full      (full[q]),
            .qry_page  (qry_page),
            .qry_hit   (q_hit[q])
        );
    end

    always_comb begin
        sel_hi   = !empty[1];
        dispatch = !busy && (empty != '1);
        pop[1]   = dispatch && sel_hi;
        pop[0]   = dispatch && !sel_hi;
        load_x   = sel_hi ? head[1] : head[0];
    end

    dmaq_active #(.PAGE_SHIFT(PAGE_SHIFT)) u_active (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (dispatch),
        .load_data (load_x),
        .load_priv (sel_hi),
        .done      (eng_done),
        .busy      (busy),
        .start     (eng_start),
        .cur_priv  (act_priv),
        .cur       (cur_x),
        .qry_page  (qry_page),
        .qry_hit   (act_hit)
    );

    assign req_full = full[req_priv];
    assign eng_src  = cur_x.src;
    assign eng_dst  = cur_x.dst;
    assign eng_cnt  = cur_x.cnt;
    assign qry_hit  = (|q_hit) || act_hit;

    AST_HI_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !empty[1]) |=> (eng_start && act_priv)); // R5
    AST_IDLE_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !empty[0]) |=> eng_start); // R6
endmodule

// File: tb/dmaq_sched_bench.sv
`timescale 1ns/1ps
module dmaq_sched_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_priv = 1'b0, eng_done = 1'b0;
    logic [15:0] req_src = '0, req_dst = '0;
    logic [11:0] req_cnt = '0;
    logic [7:0]  qry_page = '0;
    logic        req_full, eng_start, busy, qry_hit;
    logic [15:0] eng_src, eng_dst;
    logic [11:0] eng_cnt;

    always #2.5 clk = ~clk;

    dmaq_sched u_dmaq_sched (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_priv(req_priv),
        .req_src(req_src), .req_dst(req_dst), .req_cnt(req_cnt), .req_full(req_full),
        .eng_start(eng_start), .eng_src(eng_src), .eng_dst(eng_dst), .eng_cnt(eng_cnt),
        .eng_done(eng_done), .busy(busy), .qry_page(qry_page), .qry_hit(qry_hit)
    );

    localparam int D = 8;
    logic [15:0] m_src [2][D];
    logic [15:0] m_dst [2][D];
    logic [11:0] m_cnt [2][D];
    int          m_n [2];
    bit          a_v, a_start, a_priv;
    logic [15:0] a_src, a_dst;
    logic [11:0] a_cnt;
    int          n_chk = 0, n_bad = 0;
    bit          finished = 0;

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic bit exp_hit(input logic [7:0] pg);
        bit h = 0;
        for (int q = 0; q < 2; q++)
            for (int i = 0; i < m_n[q]; i++)
                if (m_src[q][i][15:8] == pg || m_dst[q][i][15:8] == pg) h = 1;
        if (a_v && (a_src[15:8] == pg || a_dst[15:8] == pg)) h = 1;
        return h;
    endfunction

    // compare all outputs with the model, then advance one clock
    task automatic step();
        bit acc, ret, disp;
        int s;
        #1;
        chk(req_full == (m_n[req_priv] == D), "R2", "req_full", req_full, m_n[req_priv] == D);
        chk(qry_hit == exp_hit(qry_page), "R8", "qry_hit", qry_hit, exp_hit(qry_page));
        chk(busy == a_v, "R7", "busy", busy, a_v);
        chk(eng_start == a_start, "R6", "eng_start", eng_start, a_start);
        if (a_v) begin
            chk(eng_src == a_src, "R4", "eng_src", eng_src, a_src);
            chk(eng_dst == a_dst, "R4", "eng_dst", eng_dst, a_dst);
            chk(eng_cnt == a_cnt, "R4", "eng_cnt", eng_cnt, a_cnt);
        end
        @(posedge clk);
        acc  = req_valid && (m_n[req_priv] < D);
        ret  = a_v && eng_done;
        disp = !a_v && (m_n[0] > 0 || m_n[1] > 0);
        a_start = 0;
        if (ret) a_v = 0;
        if (disp) begin
            s = (m_n[1] > 0) ? 1 : 0;
            a_v = 1; a_start = 1; a_priv = (s == 1);
            a_src = m_src[s][0]; a_dst = m_dst[s][0]; a_cnt = m_cnt[s][0];
            for (int i = 0; i < D - 1; i++) begin
                m_src[s][i] = m_src[s][i+1]; m_dst[s][i] = m_dst[s][i+1]; m_cnt[s][i] = m_cnt[s][i+1];
            end
            m_n[s]--;
        end
        if (acc) begin
            m_src[req_priv][m_n[req_priv]] = req_src;
            m_dst[req_priv][m_n[req_priv]] = req_dst;
            m_cnt[req_priv][m_n[req_priv]] = req_cnt;
            m_n[req_priv]++;
        end
        @(negedge clk);
    endtask

    task automatic drive(input bit v, input bit p, input logic [15:0] s, input logic [15:0] d,
                         input logic [11:0] c, input bit dn, input logic [7:0] pg);
        req_valid = v; req_priv = p; req_src = s; req_dst = d; req_cnt = c;
        eng_done = dn; qry_page = pg;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (40000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired: actual running expected done");
        finish_run();
    end

    initial begin
        m_n[0] = 0; m_n[1] = 0; a_v = 0; a_start = 0; a_priv = 0;
        a_src = '0; a_dst = '0; a_cnt = '0;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(busy == 0 && eng_start == 0, "R1", "busy/start", {busy, eng_start}, 0);
        req_priv = 0; #0.1;
        chk(req_full == 0, "R1", "req_full lo", req_full, 0);
        req_priv = 1; #0.1;
        chk(req_full == 0, "R1", "req_full hi", req_full, 0);
        qry_page = 8'h00; #0.1;
        chk(qry_hit == 0, "R1", "qry_hit", qry_hit, 0);
        rst_n = 1;
        @(negedge clk);

        // R3: fill low queue with the engine stalled; tenth request must be refused
        for (int i = 0; i < 10; i++) begin
            drive(1, 0, {8'h10 + 8'(i), 8'h00}, {8'h30 + 8'(i), 8'h04}, 12'(i + 1), 0, 8'h10 + 8'(i));
            if (i == 9) begin
                #1;
                chk(req_full == 1, "R3", "refusal at full", req_full, 1);
                @(negedge clk);
            end
            step();
        end
        drive(0, 0, 0, 0, 0, 0, 8'h19);
        step();
        chk(qry_hit == 0, "R3", "dropped page hit", qry_hit, 0);

        // R5: post two privileged requests, then release the engine
        drive(1, 1, 16'h5000, 16'h6000, 12'h040, 0, 8'h50); step();
        drive(1, 1, 16'h5100, 16'h6100, 12'h041, 0, 8'h50); step();
        drive(0, 0, 0, 0, 0, 1, 8'h50); step();
        drive(0, 0, 0, 0, 0, 0, 8'h50); step();
        chk(eng_src == 16'h5000 && eng_start, "R5", "high queue issued first", eng_src, 16'h5000);

        // R7: done while idle ignored is covered below; drain everything
        for (int i = 0; i < 40; i++) begin
            drive(0, 0, 0, 0, 0, (i % 3) == 0, 8'h10 + 8'(i % 16));
            step();
        end
        // R9: chain fully retired
        chk(busy == 0, "R9", "busy after chain", busy, 0);
        for (int p = 0; p < 16; p++) begin
            qry_page = 8'h10 + 8'(p); #0.1;
            chk(qry_hit == 0, "R9", "page after chain", qry_hit, 0);
        end
        drive(0, 0, 0, 0, 0, 1, 8'h00); step();   // R7: done while idle
        chk(busy == 0 && eng_start == 0, "R7", "idle done ignored", busy, 0);

        // random traffic over sixteen pages
        for (int i = 0; i < 4000; i++) begin
            drive($urandom_range(1, 0) == 1, $urandom_range(2, 0) == 0,
                  {4'h0, 4'($urandom_range(15, 0)), 8'($urandom)},
                  {4'h0, 4'($urandom_range(15, 0)), 8'($urandom)},
                  12'($urandom), $urandom_range(9, 0) < 3, 8'($urandom_range(15, 0)));
            step();
        end
        finish_run();
    end
endmodule